// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is the single-lane SPI master that sits in front of a serial NOR flash. It turns one request into a complete command sequence on the wire. A request carries an operation kind, an address and a byte count. Write data is pulled from a byte port, one byte per strobe, and read data is pushed out on a byte port with a valid pulse. The block raises `done` once when the sequence ends, and raises `err` alongside it when the sequence failed.

Erase and program are protected operations. The block sends a write-enable command and polls the status register until the write-enable latch is set. It then sends the command and polls again until the write-in-progress bit clears. Every poll loop has a bounded number of attempts. Addresses with a non-zero top byte use the four-byte command forms; all other addresses use three address bytes.

Straight after reset the block wakes the device from deep sleep and reads the status and configuration bytes. If the quad-enable bit is clear, it writes the bit into the configuration byte. Only after this does it accept requests.

Top module: `sflash_seq`

## Requirements
- R1: While reset is held, `spi_csn` is 1, `spi_sck` is 0 and `busy` is 1. After reset the first command sent is 0xAB (wake), followed by 0x05 (read status) and then 0x35 (read configuration), each with one returned byte. `busy` stays 1 until the start-up work is finished.
- R2: If bit 1 of the configuration byte read at start-up is 0, the block then sends 0x06 and then 0x01 with two data bytes: first the status byte it read, then the configuration byte OR 0x02. After that it polls 0x05 until bit 0 reads 0. If bit 1 is already 1, the block sends none of these commands.
- R3: `spi_csn` stays low for exactly one whole command. The command is the opcode, then the address bytes most significant first, then the data bytes. Bits go most significant first. `spi_sck` idles low, `spi_mosi` changes after falling edges and `spi_miso` is sampled on rising edges. `spi_csn` is high whenever `busy` is 0.
- R4: Kind 0 (read) sends 0x03 with three address bytes when `req_addr[31:24]` is 0, and 0x13 with four address bytes otherwise. It returns `req_len` bytes in order on `rd_data`, each with a one-cycle `rd_valid`.
- R5: A kind 0 read with `req_len` 0 gives `done` with `err` 0 within two cycles and no `spi_csn` activity.
- R6: Kind 2 (erase) sends 0x06, then polls 0x05 until bit 1 is 1. It then sends 0x20 with three address bytes (or 0x21 with four, rule as in R4). It then polls 0x05 until bit 0 is 0, and ends with `done` and `err` 0.
- R7: Kind 1 (program) follows the same sequence as R6 with opcode 0x02 or 0x12. The block sends `req_len` data bytes taken from `wr_data`, with one `wr_take` pulse per byte, and `wr_take` is only high while `spi_csn` is low.
- R8: Each poll loop allows at most POLL_LIMIT status reads, and a match on the last allowed read still counts as success. If no read matches, the block sends no further command, `spi_csn` is high, and `done` and `err` pulse together.
- R9: Kind 3 (status) sends one 0x05 command and returns its single byte on `rd_data` with `rd_valid`.
- R10: Kind 4 sends the single byte 0xB9, kind 5 sends 0xAB and kind 6 sends 0x06, each as a one-byte command followed by `done`.
- R11: Kind 7 is reserved. It gives `done` with `err` 1 and no bus activity.
- R12: `req_valid` is ignored while `busy` is 1. It produces no extra command, no extra `done` and no read data.
- R13: `done` is a one-cycle pulse, `err` is only high together with `done`, and `busy` is 0 in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is 0 |
| req_kind | input | 3 | 0 read, 1 program, 2 erase, 3 status, 4 sleep, 5 wake, 6 write-enable, 7 reserved |
| req_addr | input | 32 | Flash byte address |
| req_len | input | LEN_W | Byte count for read or program |
| wr_data | input | 8 | Program data byte, consumed when `wr_take` is high |
| wr_take | output | 1 | Program byte consumed this cycle |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| busy | output | 1 | Start-up or a request in progress |
| done | output | 1 | Sequence finished (one cycle) |
| err | output | 1 | Sequence failed (only with `done`) |
| spi_csn | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low, half the clock rate |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
In the final poll of a loop, success and timeout are decided in the same cycle: the status byte shows the awaited bit on the very read where the attempt counter reaches its limit. The bench uses a small poll limit. Its flash model holds the write-enable latch off for exactly one read fewer than the limit, and then for exactly the limit. The first case must go on to the erase opcode with `err` low. The second must stop after the last poll with `done` and `err` together and no erase command on the bus. A request arriving in the middle of an erase is the other overlap the bench provokes, and it is judged by the command log and the `done` count.

// File: rtl/sflash_seq.sv
module sflash_seq #(
  parameter int LEN_W      = 9,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             spi_csn,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int BW = LEN_W + 1;
  localparam logic [2:0] K_READ = 3'd0, K_PROG = 3'd1, K_ERASE = 3'd2, K_STAT = 3'd3,
                         K_SLEEP = 3'd4, K_WAKE = 3'd5, K_RSVD = 3'd7;

  typedef enum logic [3:0] {M_WAKE, M_RDSR0, M_RDCR0, M_WREN0, M_WRSR0, M_WIP0,
                            M_IDLE, M_CMD, M_WREN, M_WEL, M_OP, M_WIP, M_FIN} mst_t;
  typedef enum logic [1:0] {F_OFF, F_RUN, F_GAP} fst_t;

  mst_t st;
  fst_t fe;
  logic [2:0]       k_l;
  logic [31:0]      a_l;
  logic [LEN_W-1:0] n_l;
  logic [7:0]       sr_l, cr_l, rxl, sh, rx;
  logic [2:0]       bitc;
  logic [BW-1:0]    bidx, ftot;
  logic [PW-1:0]    pcnt;
  logic             sck_r, csn_r, fail;

  logic          use4;
  logic [7:0]    f_op;
  logic [2:0]    f_na;
  logic [BW-1:0] f_nd;
  logic          f_rdo, f_port, f_cfg, f_act;

  assign use4 = |a_l[31:24];

  always_comb begin
    f_op = 8'h00; f_na = 3'd0; f_nd = '0;
    f_rdo = 1'b0; f_port = 1'b0; f_cfg = 1'b0; f_act = 1'b1;
    case (st)
      M_WAKE:                       f_op = 8'hAB;
      M_RDSR0, M_WIP0, M_WEL, M_WIP: begin f_op = 8'h05; f_nd = BW'(1); end
      M_RDCR0:                      begin f_op = 8'h35; f_nd = BW'(1); end
      M_WREN0, M_WREN:              f_op = 8'h06;
      M_WRSR0:                      begin f_op = 8'h01; f_nd = BW'(2); f_cfg = 1'b1; end
      M_CMD: begin
        case (k_l)
          K_READ: begin
            f_op = use4 ? 8'h13 : 8'h03; f_na = use4 ? 3'd4 : 3'd3;
            f_nd = BW'(n_l); f_rdo = 1'b1;
          end
          K_STAT:  begin f_op = 8'h05; f_nd = BW'(1); f_rdo = 1'b1; end
          K_SLEEP: f_op = 8'hB9;
          K_WAKE:  f_op = 8'hAB;
          default: f_op = 8'h06;
        endcase
      end
      M_OP: begin
        f_na = use4 ? 3'd4 : 3'd3;
        if (k_l == K_ERASE) f_op = use4 ? 8'h21 : 8'h20;
        else begin
          f_op = use4 ? 8'h12 : 8'h02; f_nd = BW'(n_l); f_port = 1'b1;
        end
      end
      default: f_act = 1'b0;
    endcase
  end

  logic [BW-1:0] nidx, didx;
  logic [2:0]    asel;
  logic          nis_data, bend, last;
  logic [7:0]    nbyte;

  assign nidx     = bidx + 1'b1;
  assign nis_data = nidx > BW'(f_na);
  assign didx     = nidx - BW'(f_na) - 1'b1;
  assign asel     = f_na - nidx[2:0];
  assign bend     = (fe == F_RUN) && sck_r && (bitc == 3'd7);
  assign last     = (nidx == ftot);
  assign wr_take  = bend && !last && nis_data && f_port;

  always_comb begin
    if (!nis_data)  nbyte = a_l[{asel[1:0], 3'b000} +: 8];
    else if (f_port) nbyte = wr_data;
    else if (f_cfg)  nbyte = (didx == '0) ? sr_l : (cr_l | 8'h02);
    else             nbyte = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe <= F_OFF; csn_r <= 1'b1; sck_r <= 1'b0; sh <= 8'h00; rx <= 8'h00; rxl <= 8'h00;
      bitc <= 3'd0; bidx <= '0; ftot <= '0; rd_valid <= 1'b0; rd_data <= 8'h00;
    end else begin
      rd_valid <= 1'b0;
      case (fe)
        F_OFF: if (f_act) begin
          fe <= F_RUN; csn_r <= 1'b0; sh <= f_op; bitc <= 3'd0; bidx <= '0;
          ftot <= BW'(1) + BW'(f_na) + f_nd;
        end
        F_RUN: begin
          if (!sck_r) begin
            sck_r <= 1'b1;
            rx    <= {rx[6:0], spi_miso};
          end else begin
            sck_r <= 1'b0;
            bitc  <= bitc + 1'b1;
            if (bitc == 3'd7) begin
              rxl <= rx;
              if (f_rdo && (bidx > BW'(f_na))) begin
                rd_valid <= 1'b1;
                rd_data  <= rx;
              end
              if (last) begin
                fe <= F_GAP; csn_r <= 1'b1;
              end else begin
                sh <= nbyte; bidx <= nidx;
              end
            end else begin
              sh <= {sh[6:0], 1'b0};
            end
          end
        end
        default: fe <= F_OFF;
      endcase
    end
  end

  logic fdone, hit;
  assign fdone = (fe == F_GAP);
  assign hit   = (st == M_WEL) ? rxl[1] : !rxl[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= M_WAKE; k_l <= 3'd0; a_l <= '0; n_l <= '0;
      sr_l <= 8'h00; cr_l <= 8'h00; pcnt <= '0; fail <= 1'b0;
    end else begin
      case (st)
        M_IDLE: begin
          fail <= 1'b0;
          if (req_valid) begin
            k_l <= req_kind; a_l <= req_addr; n_l <= req_len;
            if (req_kind == K_RSVD) begin
              fail <= 1'b1; st <= M_FIN;
            end else if (req_kind == K_READ && req_len == '0) st <= M_FIN;
            else if (req_kind == K_ERASE || req_kind == K_PROG) st <= M_WREN;
            else st <= M_CMD;
          end
        end
        M_FIN: st <= M_IDLE;
        default: if (fdone) begin
          case (st)
            M_WAKE:  st <= M_RDSR0;
            M_RDSR0: begin sr_l <= rxl; st <= M_RDCR0; end
            M_RDCR0: begin cr_l <= rxl; st <= rxl[1] ? M_IDLE : M_WREN0; end
            M_WREN0: st <= M_WRSR0;
            M_WRSR0: begin pcnt <= '0; st <= M_WIP0; end
            M_WREN:  begin pcnt <= '0; st <= M_WEL; end
            M_OP:    begin pcnt <= '0; st <= M_WIP; end
            M_CMD:   st <= M_FIN;
            M_WIP0, M_WEL, M_WIP: begin
              if (hit) st <= (st == M_WIP0) ? M_IDLE : ((st == M_WEL) ? M_OP : M_FIN);
              else if (pcnt == PW'(POLL_LIMIT - 1)) begin
                fail <= 1'b1; st <= M_FIN;
              end else pcnt <= pcnt + 1'b1;
            end
            default: st <= M_IDLE;
          endcase
        end
      endcase
    end
  end

  assign busy     = (st != M_IDLE);
  assign done     = (st == M_FIN);
  assign err      = done && fail;
  assign spi_csn  = csn_r;
  assign spi_sck  = sck_r;
  assign spi_mosi = sh[7];

  a_r3_sck_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_sck);
  a_r3_deselected_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_csn);
  a_r7_take_inside_command: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> !spi_csn);
  a_r8_abort_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> spi_csn);
  a_r13_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  a_r13_done_single_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  a_r4_read_data_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);
endmodule

// File: tb/sflash_seq_tb.sv
`timescale 1ns/1ps
module sflash_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [31:0] req_addr = 32'd0;
  logic [8:0] req_len = 9'd0;
  logic [7:0] wr_data, rd_data;
  logic wr_take, rd_valid, busy, done, err, spi_csn, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;

  sflash_seq #(.LEN_W(9), .POLL_LIMIT(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data), .wr_take(wr_take),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .err(err),
    .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int checks = 0, fails = 0;
  bit ended = 0;

  int ntake = 0, nrd = 0, ndone = 0;
  logic lerr = 1'b0;
  logic [7:0] rbuf [0:63];
  assign wr_data = 8'hC0 + 8'(ntake);
  always @(posedge clk) begin
    if (wr_take) ntake <= ntake + 1;
    if (rd_valid) begin
      if (nrd < 64) rbuf[nrd] <= rd_data;
      nrd <= nrd + 1;
    end
    if (done) begin ndone <= ndone + 1; lerr <= err; end
  end

  // flash model
  logic [7:0] cfg = 8'h00;
  int wel_wait = 0, wip_wait = 0, wel_cnt = 0, wip_cnt = 0;
  logic wel = 1'b1;
  logic [7:0] fb [0:15];
  int nb = 0, bitn = 0, nfr = 0;
  logic [7:0] cur = 8'h00, tx = 8'h00;
  logic [7:0] lop [0:255];
  int lnb [0:255];
  logic [7:0] lb [0:255][0:15];

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] srv();
    return {6'd0, wel && (wel_cnt == 0), wip_cnt != 0};
  endfunction

  function automatic logic [7:0] resp(input int k);
    case (fb[0])
      8'h05: return srv();
      8'h35: return cfg;
      8'h03: return (k >= 4) ? pat({8'h00, fb[1], fb[2], fb[3]} + 32'(k - 4)) : 8'hFF;
      8'h13: return (k >= 5) ? pat({fb[1], fb[2], fb[3], fb[4]} + 32'(k - 5)) : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  always @(negedge spi_csn) begin bitn = 0; nb = 0; end
  always @(posedge spi_sck) if (!spi_csn) begin
    cur = {cur[6:0], spi_mosi};
    bitn = bitn + 1;
    if (bitn == 8) begin
      if (nb < 16) fb[nb] = cur;
      nb = nb + 1;
      bitn = 0;
    end
  end
  always @(negedge spi_sck) if (!spi_csn) begin
    if (bitn == 0) tx = resp(nb); else tx = {tx[6:0], 1'b0};
    spi_miso = tx[7];
  end
  always @(posedge spi_csn) if (nb > 0) begin
    if (nfr < 256) begin
      lop[nfr] = fb[0]; lnb[nfr] = nb;
      for (int i = 0; i < 16; i++) lb[nfr][i] = fb[i];
    end
    nfr = nfr + 1;
    case (fb[0])
      8'h06: begin wel = 1'b1; wel_cnt = wel_wait; end
      8'h05: begin
        if (wel_cnt > 0) wel_cnt = wel_cnt - 1;
        if (wip_cnt > 0) wip_cnt = wip_cnt - 1;
      end
      8'h20, 8'h21, 8'h02, 8'h12, 8'h01: begin wel = 1'b0; wip_cnt = wip_wait; end
      default: ;
    endcase
    nb = 0;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  task automatic run(input logic [2:0] k, input logic [31:0] a, input int n, output int cyc);
    int d0;
    d0 = ndone;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_len = 9'(n);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (ndone == d0 && cyc < 40000) begin @(negedge clk); cyc++; end
    chk(done == 1'b0 && busy == 1'b0, "R13 pulse/ready", {done, busy}, 0);
  endtask

  task automatic wait_ready();
    int t = 0;
    while (busy && t < 40000) begin @(negedge clk); t++; end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int f0, r0, t0, cyc;
    bit ok;
    // start-up with quad-enable bit clear
    cfg = 8'h00; wel = 1'b1; wel_cnt = 0; wip_wait = 2;
    repeat (3) @(negedge clk);
    chk(spi_csn == 1'b1 && spi_sck == 1'b0 && busy == 1'b1, "R1 reset state",
        {spi_csn, spi_sck, busy}, 3'b101);
    rst_n = 1'b1;
    wait_ready();
    chk(lop[0] == 8'hAB && lnb[0] == 1, "R1 wake first", lop[0], 8'hAB);
    chk(lop[1] == 8'h05 && lop[2] == 8'h35 && lnb[2] == 2, "R1 status/config reads",
        {lop[1], lop[2]}, 16'h0535);
    chk(lop[3] == 8'h06 && lop[4] == 8'h01 && lnb[4] == 3, "R2 enable+write",
        {lop[3], lop[4]}, 16'h0601);
    chk(lb[4][1] == 8'h02 && lb[4][2] == 8'h02, "R2 status/config bytes",
        {lb[4][1], lb[4][2]}, 16'h0202);
    chk(nfr == 8 && lop[7] == 8'h05, "R2 wip polls", nfr, 8);

    // read, 3-byte address
    wip_wait = 0; wel_wait = 0;
    f0 = nfr; r0 = nrd;
    run(3'd0, 32'h0001_2345, 5, cyc);
    chk(lop[f0] == 8'h03 && lnb[f0] == 9, "R4 read opcode/len", lop[f0], 8'h03);
    chk({lb[f0][1], lb[f0][2], lb[f0][3]} == 24'h012345, "R3 address MSB first",
        {lb[f0][1], lb[f0][2], lb[f0][3]}, 24'h012345);
    ok = (nrd - r0 == 5);
    for (int i = 0; i < 5; i++) if (rbuf[r0 + i] != pat(32'h12345 + 32'(i))) ok = 0;
    chk(ok, "R4 read data 3-byte", nrd - r0, 5);

    // read, 4-byte address crossing a byte carry
    f0 = nfr; r0 = nrd;
    run(3'd0, 32'h2A00_00FE, 3, cyc);
    chk(lop[f0] == 8'h13 && lnb[f0] == 8, "R4 read 4-byte opcode", lop[f0], 8'h13);
    chk({lb[f0][1], lb[f0][2], lb[f0][3], lb[f0][4]} == 32'h2A0000FE, "R3 4-byte address",
        {lb[f0][1], lb[f0][2], lb[f0][3], lb[f0][4]}, 32'h2A0000FE);
    ok = (nrd - r0 == 3);
    for (int i = 0; i < 3; i++) if (rbuf[r0 + i] != pat(32'h2A0000FE + 32'(i))) ok = 0;
    chk(ok, "R4 read data 4-byte", nrd - r0, 3);

    // zero-length read
    f0 = nfr; r0 = nrd;
    run(3'd0, 32'h0000_0100, 0, cyc);
    chk(cyc <= 2 && lerr == 1'b0, "R5 zero read completes", cyc, 2);
    chk(nfr == f0 && nrd == r0, "R5 no bus activity", nfr - f0, 0);

    // status read
    wel = 1'b1; wel_cnt = 0;
    f0 = nfr; r0 = nrd;
    run(3'd3, 32'h0, 0, cyc);
    chk(lop[f0] == 8'h05 && nrd - r0 == 1 && rbuf[r0] == 8'h02, "R9 status read",
        rbuf[r0], 8'h02);

    // erase with waits
    wel_wait = 2; wip_wait = 3;
    f0 = nfr;
    run(3'd2, 32'h00AB_C000, 0, cyc);
    ok = (lop[f0] == 8'h06) && (nfr - f0 == 9);
    for (int i = 1; i <= 3; i++) if (lop[f0 + i] != 8'h05) ok = 0;
    for (int i = 5; i <= 8; i++) if (lop[f0 + i] != 8'h05) ok = 0;
    chk(ok, "R6 erase sequence", nfr - f0, 9);
    chk(lop[f0 + 4] == 8'h20 && lnb[f0 + 4] == 4 &&
        {lb[f0 + 4][1], lb[f0 + 4][2], lb[f0 + 4][3]} == 24'hABC000 && lerr == 1'b0,
        "R6 erase command", lop[f0 + 4], 8'h20);

    // program, 4-byte address
    wel_wait = 0; wip_wait = 0;
    f0 = nfr; t0 = ntake;
    run(3'd1, 32'h0100_0100, 4, cyc);
    chk(nfr - f0 == 4 && lop[f0] == 8'h06 && lop[f0 + 1] == 8'h05 && lop[f0 + 2] == 8'h12 &&
        lop[f0 + 3] == 8'h05 && lnb[f0 + 2] == 9, "R7 program sequence", lop[f0 + 2], 8'h12);
    ok = (ntake - t0 == 4);
    for (int i = 0; i < 4; i++) if (lb[f0 + 2][5 + i] != 8'hC0 + 8'(t0 + i)) ok = 0;
    chk(ok, "R7 program data", ntake - t0, 4);

    // poll limit boundary: success on the last allowed poll
    wel_wait = 7;
    f0 = nfr;
    run(3'd2, 32'h0000_1000, 0, cyc);
    chk(lerr == 1'b0 && nfr - f0 == 11 && lop[f0 + 9] == 8'h20, "R8 last poll succeeds",
        nfr - f0, 11);

    // poll limit exceeded on write-enable latch
    wel_wait = 8;
    f0 = nfr;
    run(3'd2, 32'h0000_1000, 0, cyc);
    chk(lerr == 1'b1 && nfr - f0 == 9 && spi_csn == 1'b1, "R8 latch timeout abort",
        nfr - f0, 9);

    // poll limit exceeded on write-in-progress
    wel_wait = 0; wip_wait = 8;
    f0 = nfr;
    run(3'd1, 32'h0000_0200, 1, cyc);
    chk(lerr == 1'b1 && nfr - f0 == 11 && lop[f0 + 2] == 8'h02, "R8 busy timeout",
        nfr - f0, 11);
    wip_wait = 0; wip_cnt = 0;

    // single-byte commands
    f0 = nfr;
    run(3'd4, 32'h0, 0, cyc);
    run(3'd5, 32'h0, 0, cyc);
    run(3'd6, 32'h0, 0, cyc);
    chk(nfr - f0 == 3 && lop[f0] == 8'hB9 && lop[f0 + 1] == 8'hAB && lop[f0 + 2] == 8'h06 &&
        lnb[f0] == 1 && lnb[f0 + 1] == 1 && lnb[f0 + 2] == 1, "R10 sleep/wake/enable",
        {lop[f0], lop[f0 + 1], lop[f0 + 2]}, 24'hB9AB06);

    // reserved kind
    f0 = nfr;
    run(3'd7, 32'h0, 0, cyc);
    chk(lerr == 1'b1 && nfr == f0, "R11 reserved kind", lerr, 1);

    // request during a busy erase is ignored
    wel_wait = 3;
    f0 = nfr; r0 = nrd; t0 = ndone;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd2; req_addr = 32'h0000_3000; req_len = 9'd0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd0; req_addr = 32'h0000_0040; req_len = 9'd2;
    @(negedge clk);
    req_valid = 1'b0;
    wait_ready();
    repeat (300) @(negedge clk);
    chk(ndone - t0 == 1 && nrd == r0 && nfr - f0 == 7 && lop[f0 + 5] == 8'h20,
        "R12 request while busy", nfr - f0, 7);

    // start-up with quad-enable bit already set
    cfg = 8'h02; wel_wait = 0;
    f0 = nfr;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    wait_ready();
    repeat (20) @(negedge clk);
    chk(nfr - f0 == 3 && lop[f0] == 8'hAB && lop[f0 + 2] == 8'h35, "R2 no write when set",
        nfr - f0, 3);

    summary();
    $finish;
  end
endmodule